// File: doc/BRIEF.md
# Write-Combining Store Buffer

This block sits between a processor's store path and a device bus for an address region where stores may be gathered. It collects byte-enabled stores into a small pool of 64-byte line entries. Each entry records which of its bytes have been written. A later store to a line that is already held merges into that entry. The block sends whole lines out on a valid/ready channel, with a per-byte mask that marks the bytes actually written.

A line leaves the buffer in three cases. It leaves by itself as soon as every one of its bytes has been written. It leaves when a store to a new line finds no free entry, in which case the oldest entry is forced out. All entries leave when any fence-class event is signalled. While a fence is draining, new stores are held off. A single-cycle done pulse marks the point where the buffer is empty again, so every store accepted before the fence has been issued before any store accepted after it.

Top module: `wcBuffer`

## Requirements
- R1: A store whose line address matches a resident entry that is not on the output merges into it. The latest data written to a byte wins, and the entry's mask is the union of all byte enables.
- R2: A partly written entry produces no output for as long as no event arrives and no new line needs its slot.
- R3: When a store completes all 64 bytes of an entry and the output channel was idle, `outValid` is high in the next cycle with `outMask` all ones.
- R4: A store to a new line while all entries are occupied sees `storeReady` low. In that same cycle the oldest entry is presented on the output. The store is accepted in the cycle after that entry's handshake.
- R5: Each bit of `fenceEvt` forces every resident entry out, oldest allocation first. The bits are: bit 0 store fence, bit 1 full fence, bit 2 serializing instruction, bit 3 uncached access, bit 4 interrupt, bit 5 locked operation.
- R6: `busy` is high from the cycle after an event until `fenceDone`, and `storeReady` is low while `busy` is high. `fenceDone` is a one-cycle pulse. It comes in the cycle after the last entry's handshake, or in the cycle after the event if the buffer was already empty.
- R7: While `outValid` is high and `outReady` is low, `outValid`, `outLine`, `outData` and `outMask` hold their values.
- R8: A store to the line of the entry being presented never merges into it. It opens a fresh entry, including in the cycle of that entry's handshake. The departing line carries only its earlier data.
- R9: In an issued line, bytes never written read as zero, and each `outMask` bit is set exactly for a written byte.
- R10: After reset, `storeReady` is high and `outValid`, `busy` and `fenceDone` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| storeValid | input | 1 | Store request present |
| storeReady | output | 1 | Store accepted this cycle when high together with storeValid |
| storeLine | input | 26 | Line address of the store (byte address / 64) |
| storeData | input | 512 | Store data, byte b in bits 8b+7..8b |
| storeBe | input | 64 | Byte enables of the store |
| fenceEvt | input | 6 | Fence-class event strobes (encoding in R5) |
| busy | output | 1 | Fence drain in progress |
| fenceDone | output | 1 | One-cycle pulse: drain finished |
| outValid | output | 1 | Line write presented |
| outReady | input | 1 | Downstream accepts the line |
| outLine | output | 26 | Line address of the write |
| outData | output | 512 | Line data |
| outMask | output | 64 | Written-byte mask |

## Verification
Two things can fall in the same clock edge: the output handshake of a full line, and a store to that same line. The bench holds a completed line on the output with ready low. In a single cycle it then raises ready and drives a one-byte store to that line. It judges the outcome at the ports: the departing line must carry its earlier byte value, the new byte must stay held as a fresh partial entry, and it must appear alone, with a one-bit mask, after a later fence. The random phase also lets stores, pressure evictions and random ready stalls overlap freely. After every fence it compares the image built from issued lines against a byte image computed from the accepted stores.

// File: rtl/wcbPkg.sv
package wcbPkg;
  localparam int ENTRIES    = 4;
  localparam int IDX_W      = $clog2(ENTRIES);
  localparam int LINE_BYTES = 64;
  localparam int LINE_AW    = 26;
  localparam int EVT_W      = 6;

  // strobes from control to the entry storage
  typedef struct packed {
    logic             allocEn;
    logic [IDX_W-1:0] allocIdx;
    logic             mergeEn;
    logic [IDX_W-1:0] mergeIdx;
    logic             freeEn;
    logic [IDX_W-1:0] freeIdx;
  } wcbStrobes_t;
endpackage

// File: rtl/wcbData.sv
module wcbData
  import wcbPkg::*;
#(
  parameter int LINE_AW    = wcbPkg::LINE_AW,
  parameter int LINE_BYTES = wcbPkg::LINE_BYTES,
  localparam int DATA_W    = LINE_BYTES * 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  wcbStrobes_t           strb,
  input  logic [LINE_AW-1:0]    storeLine,
  input  logic [DATA_W-1:0]     storeData,
  input  logic [LINE_BYTES-1:0] storeBe,
  input  logic [IDX_W-1:0]      pickIdx,
  output logic [ENTRIES-1:0]    entValid,
  output logic [LINE_AW-1:0]    entLine [ENTRIES],
  output logic [ENTRIES-1:0]    entFull,
  output logic [IDX_W-1:0]      entRank [ENTRIES],
  output logic [LINE_AW-1:0]    outLine,
  output logic [DATA_W-1:0]     outData,
  output logic [LINE_BYTES-1:0] outMask
);
  logic [ENTRIES-1:0]    validQ;
  logic [LINE_AW-1:0]    lineQ [ENTRIES];
  logic [DATA_W-1:0]     dataQ [ENTRIES];
  logic [LINE_BYTES-1:0] maskQ [ENTRIES];
  logic [IDX_W-1:0]      rankQ [ENTRIES];
  logic [IDX_W:0]        liveCount;
  logic [IDX_W-1:0]      newRank;

  // age rank of a newly allocated entry = number of entries that survive this cycle
  always_comb begin
    liveCount = '0;
    for (int i = 0; i < ENTRIES; i++) liveCount = liveCount + (IDX_W+1)'(validQ[i]);
    newRank = IDX_W'(liveCount - (IDX_W+1)'(strb.freeEn));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validQ <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        lineQ[i] <= '0;
        dataQ[i] <= '0;
        maskQ[i] <= '0;
        rankQ[i] <= '0;
      end
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (strb.freeEn && strb.freeIdx == IDX_W'(i)) begin
          validQ[i] <= 1'b0;
        end else if (validQ[i] && strb.freeEn && rankQ[i] > rankQ[strb.freeIdx]) begin
          rankQ[i] <= rankQ[i] - IDX_W'(1);
        end
        if (strb.allocEn && strb.allocIdx == IDX_W'(i)) begin
          validQ[i] <= 1'b1;
          lineQ[i]  <= storeLine;
          rankQ[i]  <= newRank;
          maskQ[i]  <= storeBe;
          for (int b = 0; b < LINE_BYTES; b++)
            dataQ[i][8*b +: 8] <= storeBe[b] ? storeData[8*b +: 8] : 8'h00;
        end
        if (strb.mergeEn && strb.mergeIdx == IDX_W'(i)) begin
          maskQ[i] <= maskQ[i] | storeBe;
          for (int b = 0; b < LINE_BYTES; b++)
            if (storeBe[b]) dataQ[i][8*b +: 8] <= storeData[8*b +: 8];
        end
      end
    end
  end

  always_comb begin
    for (int i = 0; i < ENTRIES; i++) begin
      entFull[i] = &maskQ[i];
      entLine[i] = lineQ[i];
      entRank[i] = rankQ[i];
    end
  end

  assign entValid = validQ;
  assign outLine  = lineQ[pickIdx];
  assign outData  = dataQ[pickIdx];
  assign outMask  = maskQ[pickIdx];
endmodule

// File: rtl/wcbCtrl.sv
module wcbCtrl
  import wcbPkg::*;
#(
  parameter int LINE_AW = wcbPkg::LINE_AW
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               storeValid,
  input  logic [LINE_AW-1:0] storeLine,
  input  logic [EVT_W-1:0]   fenceEvt,
  input  logic               outReady,
  input  logic [ENTRIES-1:0] entValid,
  input  logic [LINE_AW-1:0] entLine [ENTRIES],
  input  logic [ENTRIES-1:0] entFull,
  input  logic [IDX_W-1:0]   entRank [ENTRIES],
  output logic               storeReady,
  output logic               busy,
  output logic               fenceDone,
  output logic               outValid,
  output logic [IDX_W-1:0]   pickIdx,
  output wcbStrobes_t        strb
);
  logic               lockValid;
  logic [IDX_W-1:0]   lockIdx;
  logic               fenceActive;
  logic [ENTRIES-1:0] rawMatch, effMatch, eligible, presented;
  logic               freeAvail, pressure, accept, bestFound;
  logic [IDX_W-1:0]   freeIdx, mergeIdx, bestIdx, bestRank;

  always_comb begin
    freeAvail = 1'b0;
    freeIdx   = '0;
    for (int i = ENTRIES-1; i >= 0; i--) begin
      rawMatch[i] = entValid[i] && (entLine[i] == storeLine);
      if (!entValid[i]) begin
        freeAvail = 1'b1;
        freeIdx   = IDX_W'(i);
      end
    end
    // a new line with no free slot forces the oldest entry out
    pressure = storeValid && !fenceActive && !freeAvail && !(|rawMatch);
    for (int i = 0; i < ENTRIES; i++)
      eligible[i] = entValid[i] && (entFull[i] || fenceActive || (pressure && entRank[i] == '0));
    bestFound = 1'b0;
    bestIdx   = '0;
    bestRank  = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (eligible[i] && (!bestFound || entRank[i] < bestRank)) begin
        bestFound = 1'b1;
        bestIdx   = IDX_W'(i);
        bestRank  = entRank[i];
      end
    end
    pickIdx   = lockValid ? lockIdx : bestIdx;
    outValid  = lockValid || bestFound;
    presented = '0;
    if (outValid) presented[pickIdx] = 1'b1;
    // the presented entry is frozen: its line goes to a fresh entry
    effMatch = rawMatch & ~presented;
    mergeIdx = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (effMatch[i]) mergeIdx = IDX_W'(i);
    storeReady = !fenceActive && ((|effMatch) || freeAvail);
    accept     = storeValid && storeReady;
    fenceDone  = fenceActive && !(|entValid);
    busy       = fenceActive;
    strb.allocEn  = accept && !(|effMatch);
    strb.allocIdx = freeIdx;
    strb.mergeEn  = accept && (|effMatch);
    strb.mergeIdx = mergeIdx;
    strb.freeEn   = outValid && outReady;
    strb.freeIdx  = pickIdx;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lockValid   <= 1'b0;
      lockIdx     <= '0;
      fenceActive <= 1'b0;
    end else begin
      lockValid   <= outValid && !outReady;
      lockIdx     <= pickIdx;
      fenceActive <= (|fenceEvt) || (fenceActive && !fenceDone);
    end
  end
endmodule

// File: rtl/wcBuffer.sv
module wcBuffer
  import wcbPkg::*;
#(
  parameter int LINE_AW    = wcbPkg::LINE_AW,
  parameter int LINE_BYTES = wcbPkg::LINE_BYTES,
  localparam int DATA_W    = LINE_BYTES * 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  storeValid,
  output logic                  storeReady,
  input  logic [LINE_AW-1:0]    storeLine,
  input  logic [DATA_W-1:0]     storeData,
  input  logic [LINE_BYTES-1:0] storeBe,
  input  logic [EVT_W-1:0]      fenceEvt,
  output logic                  busy,
  output logic                  fenceDone,
  output logic                  outValid,
  input  logic                  outReady,
  output logic [LINE_AW-1:0]    outLine,
  output logic [DATA_W-1:0]     outData,
  output logic [LINE_BYTES-1:0] outMask
);
  wcbStrobes_t        strb;
  logic [ENTRIES-1:0] entValid, entFull;
  logic [LINE_AW-1:0] entLine [ENTRIES];
  logic [IDX_W-1:0]   entRank [ENTRIES];
  logic [IDX_W-1:0]   pickIdx;

  wcbCtrl #(.LINE_AW(LINE_AW)) i_ctrl (
    .clk, .rstN, .storeValid, .storeLine, .fenceEvt, .outReady,
    .entValid, .entLine, .entFull, .entRank,
    .storeReady, .busy, .fenceDone, .outValid, .pickIdx, .strb
  );

  wcbData #(.LINE_AW(LINE_AW), .LINE_BYTES(LINE_BYTES)) i_data (
    .clk, .rstN, .strb, .storeLine, .storeData, .storeBe, .pickIdx,
    .entValid, .entLine, .entFull, .entRank, .outLine, .outData, .outMask
  );
endmodule

// File: rtl/wcbChecker.sv
module wcbChecker
  import wcbPkg::*;
#(
  parameter int LINE_AW    = wcbPkg::LINE_AW,
  parameter int LINE_BYTES = wcbPkg::LINE_BYTES,
  localparam int DATA_W    = LINE_BYTES * 8
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  storeValid,
  input logic                  storeReady,
  input logic [LINE_AW-1:0]    storeLine,
  input logic [DATA_W-1:0]     storeData,
  input logic [LINE_BYTES-1:0] storeBe,
  input logic [EVT_W-1:0]      fenceEvt,
  input logic                  busy,
  input logic                  fenceDone,
  input logic                  outValid,
  input logic                  outReady,
  input logic [LINE_AW-1:0]    outLine,
  input logic [DATA_W-1:0]     outData,
  input logic [LINE_BYTES-1:0] outMask
);
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid && $stable(outLine) && $stable(outData) && $stable(outMask));

  assert_no_store_busy_R6: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !storeReady);

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rstN)
    fenceDone |=> !fenceDone);

  assert_done_empty_R6: assert property (@(posedge clk) disable iff (!rstN)
    fenceDone |-> !outValid);

  assert_event_busy_R6: assert property (@(posedge clk) disable iff (!rstN)
    (|fenceEvt) |=> busy);

  assert_full_issue_R3: assert property (@(posedge clk) disable iff (!rstN)
    storeValid && storeReady && (&storeBe) && !outValid |=> outValid);

  assert_mask_nonzero_R9: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> outMask != '0);
endmodule

bind wcBuffer wcbChecker #(.LINE_AW(LINE_AW), .LINE_BYTES(LINE_BYTES)) i_wcbChecker (.*);

// File: tb/test_wcBuffer.sv
module test_wcBuffer;
  localparam int LAW = 26;
  localparam int NL  = 16;
  localparam int HMAX = 1024;

  logic clk = 0, rstN = 0;
  logic storeValid = 0;
  logic [LAW-1:0] storeLine = '0;
  logic [511:0] storeData = '0;
  logic [63:0] storeBe = '0;
  logic [5:0] fenceEvt = '0;
  logic dirReady = 1, rndReady = 0, rndBit = 0;
  logic outReady;
  logic storeReady, busy, fenceDone, outValid;
  logic [LAW-1:0] outLine;
  logic [511:0] outData;
  logic [63:0] outMask;

  int nErr = 0, nChecks = 0, hsCount = 0, busyViol = 0;
  logic [7:0] expImg [NL][64];
  logic [7:0] devImg [NL][64];
  int hsLine [HMAX];
  logic [63:0] hsMask [HMAX];
  logic [511:0] hsData [HMAX];

  assign outReady = rndReady ? rndBit : dirReady;
  always #2 clk = ~clk;

  wcBuffer i_wcBuffer (
    .clk, .rstN, .storeValid, .storeReady, .storeLine, .storeData, .storeBe,
    .fenceEvt, .busy, .fenceDone, .outValid, .outReady, .outLine, .outData, .outMask
  );

  always @(posedge clk) begin
    #1 rndBit = 1'($urandom % 2);
  end

  // handshake monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (rstN && busy && storeReady) busyViol++;
    if (rstN && outValid && outReady) begin
      if (hsCount < HMAX) begin
        hsLine[hsCount] = int'(outLine);
        hsMask[hsCount] = outMask;
        hsData[hsCount] = outData;
      end
      hsCount++;
      if (outLine < NL)
        for (int b = 0; b < 64; b++)
          if (outMask[b]) devImg[outLine][b] = outData[8*b +: 8];
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [511:0] rndLine();
    logic [511:0] r;
    for (int w = 0; w < 16; w++) r[32*w +: 32] = $urandom;
    return r;
  endfunction

  function automatic logic [511:0] keepBytes(input logic [511:0] d, input logic [63:0] m);
    logic [511:0] r;
    for (int b = 0; b < 64; b++) r[8*b +: 8] = m[b] ? d[8*b +: 8] : 8'h00;
    return r;
  endfunction

  function automatic int imgDiff();
    int n = 0;
    for (int l = 0; l < NL; l++)
      for (int b = 0; b < 64; b++)
        if (expImg[l][b] !== devImg[l][b]) n++;
    return n;
  endfunction

  // called at posedge+1; returns at posedge+1 after acceptance
  task automatic doStore(input int ln, input logic [511:0] d, input logic [63:0] be);
    storeValid = 1; storeLine = LAW'(ln); storeData = d; storeBe = be;
    @(negedge clk);
    while (!storeReady) @(negedge clk);
    @(posedge clk); #1;
    storeValid = 0;
    for (int b = 0; b < 64; b++) if (be[b]) expImg[ln][b] = d[8*b +: 8];
  endtask

  task automatic doFence(input int k);
    fenceEvt = 6'(1 << k);
    @(posedge clk); #1;
    fenceEvt = '0;
    @(negedge clk);
    while (!fenceDone) @(negedge clk);
    @(posedge clk); #1;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nErr++; nChecks++;
    $display("FAIL watchdog: run did not finish actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin : main
    logic [511:0] a, bb, c, d, e, f, g, snapD;
    logic [LAW-1:0] snapL;
    logic [63:0] snapM;
    int start, held;
    void'($urandom(32'd20240611));
    for (int l = 0; l < NL; l++)
      for (int b = 0; b < 64; b++) begin expImg[l][b] = 8'h00; devImg[l][b] = 8'h00; end

    // R10 reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(storeReady == 1'b1, "R10 storeReady", 64'(storeReady), 64'd1);
    chk(!outValid && !busy && !fenceDone, "R10 outputs idle", {outValid, busy, fenceDone}, 64'd0);
    @(posedge clk); #1 rstN = 1;

    // R2 partial entry held, R1 merge with overwrite
    dirReady = 0;
    a = rndLine(); bb = rndLine(); c = rndLine();
    doStore(5, a, 64'hFF);
    doStore(5, bb, 64'h1);
    held = 0;
    repeat (20) begin @(negedge clk); if (outValid) held++; end
    chk(held == 0, "R2 partial line not issued", 64'(held), 64'd0);
    @(posedge clk); #1;
    doStore(5, c, ~64'hFF);
    @(negedge clk);
    chk(outValid == 1'b1, "R3 full line issued next cycle", 64'(outValid), 64'd1);
    chk(outLine == 5 && outMask == '1, "R1 merged mask", outMask, 64'hFFFF_FFFF_FFFF_FFFF);
    chk(outData[7:0] == bb[7:0] && outData[15:8] == a[15:8] && outData[71:64] == c[71:64],
        "R1 latest byte wins", 64'(outData[15:0]), {48'd0, a[15:8], bb[7:0]});
    snapD = outData; snapL = outLine; snapM = outMask;
    repeat (3) @(negedge clk);
    chk(outValid && outData == snapD && outLine == snapL && outMask == snapM,
        "R7 held while stalled", 64'(outLine), 64'(snapL));
    @(posedge clk); #1 dirReady = 1;
    @(posedge clk);
    @(negedge clk);
    chk(outValid == 1'b0, "R3 entry freed after handshake", 64'(outValid), 64'd0);

    // R9 unwritten bytes zero
    @(posedge clk); #1;
    d = rndLine();
    start = hsCount;
    doStore(7, d, 64'h0F00);
    doFence(0);
    chk(hsCount == start + 1 && hsLine[start] == 7 && hsMask[start] == 64'h0F00,
        "R9 mask of partial line", hsMask[start], 64'h0F00);
    chk(hsData[start] == keepBytes(d, 64'h0F00), "R9 zero bytes", hsData[start][127:64],
        keepBytes(d, 64'h0F00) >> 64);

    // R4 eviction of oldest under pressure
    dirReady = 0;
    for (int l = 1; l <= 4; l++) doStore(l, rndLine(), 64'h1);
    g = rndLine();
    storeValid = 1; storeLine = 9; storeData = g; storeBe = 64'h3;
    @(negedge clk);
    chk(storeReady == 1'b0, "R4 store stalled when full", 64'(storeReady), 64'd0);
    chk(outValid && outLine == 1, "R4 oldest presented", 64'(outLine), 64'd1);
    @(posedge clk); #1 dirReady = 1;
    start = hsCount;
    doStore(9, g, 64'h3);
    chk(hsCount == start + 1 && hsLine[start] == 1, "R4 oldest evicted first", 64'(hsLine[start]), 64'd1);
    doFence(3);
    chk(hsCount == start + 5 && hsLine[start+1] == 2 && hsLine[start+2] == 3 &&
        hsLine[start+3] == 4 && hsLine[start+4] == 9, "R5 drain in allocation order",
        64'(hsLine[start+4]), 64'd9);

    // R5/R6 each event bit drains everything
    for (int k = 0; k < 6; k++) begin
      doStore(10, rndLine(), 64'h3);
      doStore(11, rndLine(), 64'h30);
      start = hsCount;
      fenceEvt = 6'(1 << k);
      @(posedge clk); #1 fenceEvt = '0;
      @(negedge clk);
      chk(busy && !storeReady, "R6 busy blocks stores", {busy, storeReady}, 64'b10);
      while (!fenceDone) @(negedge clk);
      chk(hsCount == start + 2 && hsLine[start] == 10 && hsLine[start+1] == 11,
          "R5 event bit drains all", 64'(hsCount - start), 64'd2);
      @(negedge clk);
      chk(!fenceDone && !busy, "R6 done is one pulse", {fenceDone, busy}, 64'd0);
      @(posedge clk); #1;
    end

    // R6 fence on empty buffer
    fenceEvt = 6'b100000;
    @(posedge clk); #1 fenceEvt = '0;
    @(negedge clk);
    chk(fenceDone == 1'b1, "R6 done after empty fence", 64'(fenceDone), 64'd1);
    @(negedge clk);
    chk(fenceDone == 1'b0 && busy == 1'b0, "R6 empty fence ends", {fenceDone, busy}, 64'd0);
    @(posedge clk); #1;

    // R8 store to departing line in its handshake cycle
    dirReady = 0;
    e = rndLine(); f = rndLine();
    doStore(6, e, '1);
    @(negedge clk);
    chk(outValid && outLine == 6, "R8 full line presented", 64'(outLine), 64'd6);
    @(posedge clk); #1;
    dirReady = 1;
    start = hsCount;
    doStore(6, f, 64'h1);
    chk(hsCount == start + 1 && hsData[start][7:0] == e[7:0] && hsMask[start] == '1,
        "R8 departing line keeps old byte", 64'(hsData[start][7:0]), 64'(e[7:0]));
    @(negedge clk);
    chk(outValid == 1'b0, "R8 new byte held in fresh entry", 64'(outValid), 64'd0);
    @(posedge clk); #1;
    doFence(1);
    chk(hsCount == start + 2 && hsLine[start+1] == 6 && hsMask[start+1] == 64'h1 &&
        hsData[start+1][7:0] == f[7:0], "R8 fresh entry issued alone", hsMask[start+1], 64'h1);

    // random phase: R1 image consistency
    rndReady = 1;
    for (int it = 0; it < 400; it++) begin
      logic [63:0] be;
      int ln;
      ln = $urandom % 6;
      if ($urandom % 8 == 0) be = '1;
      else be = 64'hFF << (8 * ($urandom % 8));
      doStore(ln, rndLine(), be);
      if ($urandom % 25 == 0) begin
        doFence($urandom % 6);
        chk(imgDiff() == 0, "R1 issued image matches stores", 64'(imgDiff()), 64'd0);
      end
    end
    doFence(2);
    chk(imgDiff() == 0, "R1 final image", 64'(imgDiff()), 64'd0);
    chk(busyViol == 0, "R6 no store accepted while busy", 64'(busyViol), 64'd0);
    rndReady = 0;

    summary();
    $finish;
  end
endmodule